// File: doc/BRIEF.md
# I2C Master with Sub-Address Sequencing

This block is a single-master I2C controller that software drives through eight byte-wide registers. Software loads a target address and an optional sub-address, then writes a start command. The hardware runs the address phase and, depending on the selected format, the sub-address byte and a repeated start. It pauses with SCL held low whenever software has to act. Software paces the data bytes: it writes the data register to send a byte, or clears a completion flag to receive the next byte. Event flags mark address completion, data-byte completion, stop completion and start generation. Each flag can be masked onto a single interrupt line.

There are three transfer formats. Plain format sends the address byte and then moves data in the direction of its R/W bit. Sub-address format sends the address byte, then an 8-bit sub-address, then data. Read-after-sub-address format first sends the address with the write bit and then the sub-address. It then issues a repeated start and sends the address with the read bit, and data is read after that.

The bus uses open-drain style pull-down enables, one SCL and one SDA pair for each of two ports, and reads back the SDA level of each port. The port is chosen by a channel field. SCL comes from a prescaler with four quarter-periods per bit, at one of three rates.

Top module: `i2c_sub_master`

## Requirements
- R1: After reset, status reads 0 (not busy, no acknowledge), the event register reads 0, the interrupt line is low, and no SCL or SDA line is pulled on any port.
- R2: Register map, by reg_addr: 0 mode, 1 control, 2 status, 3 events, 4 event mask, 5 target address byte, 6 sub-address, 7 data. In plain format (mode[3:2]=0), control bit 0 sends the address byte. Each write of the data register while the transfer is paused and writing then sends one byte. The transfer pauses after each acknowledge clock, with the data-done event (bit 1) set.
- R3: In sub-address format (mode[3:2]=1, and 3 behaves the same), the sub-address byte follows the address byte before any data. The address-done event (bit 0) is raised only after the sub-address is acknowledged.
- R4: In read-after-sub-address format (mode[3:2]=2), the first address goes out with R/W=0, then the sub-address, then a repeated start and the address with R/W=1. The data phase then reads.
- R5: While paused in a read, writing 1 to event bit 0 or 1 receives one byte into the data register. The byte is acknowledged if control bit 2 was set, and otherwise ends with a NAK followed by an automatic stop.
- R6: A NAK on an address or sub-address phase clears status bit 1, raises the address-done event, issues a stop without software action, and then raises stop-done (bit 2).
- R7: Control bit 1, written while paused, issues a stop. Status bit 0 (busy) stays set until the stop condition completes.
- R8: Event bits are cleared by writing 1 and are unchanged by writing 0. The interrupt line is high exactly when an event bit and its mask bit (register 4) are both set.
- R9: Event bit 3 is raised when a start condition has been generated.
- R10: Mode bit 4 selects bus port 0 or 1, and the other port's lines stay released.
- R11: The SCL period is 4 x QDIV x 2^rate system clocks, with rate = mode[1:0] (0, 1 or 2, and 3 behaves as 2).
- R12: Writes to the mode register are ignored while busy.
- R13: A NAK on a written data byte clears status bit 1. The controller then stays busy with SCL held low until software commands a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Masked event interrupt |
| scl_pull | output | NPORT | Per-port SCL pull-low enable |
| sda_pull | output | NPORT | Per-port SDA pull-low enable |
| sda_in | input | NPORT | Per-port SDA line level |

## Verification
The hardest situation to reach is the repeated start in read-after-sub-address format. It only occurs after the target has acknowledged both the address and the sub-address, so the bench needs a behavioural target that decodes start and stop conditions, keeps a register pointer and changes from receiver to transmitter on the second address. A combined read is run back to back after a sub-address write that has placed known bytes. The bytes returned, the R/W bit the target observed and the automatic stop after the NAK'd last byte together show that the sequence took place. The wait after a data-byte NAK is reached by configuring the target to refuse data bytes while still accepting the pointer byte.

// File: rtl/i2c_sub_master.sv
module i2c_sub_master #(
  parameter int QDIV  = 4,
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic [NPORT-1:0] scl_pull,
  output logic [NPORT-1:0] sda_pull,
  input  logic [NPORT-1:0] sda_in
);
  localparam int PW = $clog2(QDIV * 4) + 1;
  localparam int CW = (NPORT > 1) ? $clog2(NPORT) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_SUB, S_RSTART, S_ADDR2, S_HOLD, S_WR, S_RD, S_STOP
  } st_t;

  st_t          st;
  logic [7:0]   mode_r, taddr, sub_r, data_r;
  logic [3:0]   isr, ier, bitn;
  logic         ack_en, busy, last_ack, sbit, sda_last, nak_rd;
  logic [1:0]   q;
  logic [8:0]   sh;
  logic [PW-1:0] pcnt;

  logic [1:0]   rate;
  logic [PW-1:0] qlen;
  logic [CW-1:0] ch;
  logic         isstd, iscomb, rd_dir, bitst, tick, endsym, done, acked;
  logic         go, stop_cmd, data_we, isr_we;
  logic         scl_rel, sda_val;
  logic [3:0]   isr_set, isr_clr;

  assign rate    = (mode_r[1:0] == 2'd3) ? 2'd2 : mode_r[1:0];
  assign qlen    = PW'(QDIV) << rate;
  assign ch      = mode_r[4 +: CW];
  assign isstd   = mode_r[3:2] == 2'd0;
  assign iscomb  = mode_r[3:2] == 2'd2;
  assign rd_dir  = iscomb | taddr[0];
  assign bitst   = st inside {S_ADDR, S_SUB, S_ADDR2, S_WR, S_RD};
  assign tick    = !(st inside {S_IDLE, S_HOLD}) && (pcnt == qlen - 1'b1);
  assign endsym  = tick && (q == 2'd3);
  assign done    = endsym && bitst && (bitn == 4'd8);
  assign acked   = ~sbit;

  assign go       = reg_we && reg_addr == 3'd1 && reg_wdata[0];
  assign stop_cmd = reg_we && reg_addr == 3'd1 && reg_wdata[1];
  assign data_we  = reg_we && reg_addr == 3'd7;
  assign isr_we   = reg_we && reg_addr == 3'd3;
  assign isr_clr  = isr_we ? reg_wdata[3:0] : 4'd0;

  always_comb begin
    isr_set    = 4'd0;
    isr_set[3] = endsym && (st == S_START || st == S_RSTART);
    isr_set[0] = done && ((st == S_ADDR2) ||
                          (st == S_ADDR && (!acked || isstd)) ||
                          (st == S_SUB  && (!acked || !iscomb)));
    isr_set[1] = done && (st == S_WR || st == S_RD);
    isr_set[2] = endsym && st == S_STOP;
  end

  always_comb begin
    scl_rel = 1'b1;
    sda_val = 1'b1;
    case (st)
      S_IDLE: ;
      S_HOLD: begin scl_rel = 1'b0; sda_val = sda_last; end
      default: begin
        scl_rel = q[1];
        if (q == 2'd0)                         sda_val = sda_last;
        else if (st == S_START || st == S_RSTART) sda_val = (q != 2'd3);
        else if (st == S_STOP)                 sda_val = (q == 2'd3);
        else                                   sda_val = sh[8];
      end
    endcase
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign scl_pull[p] = (ch == CW'(p)) && !scl_rel;
    assign sda_pull[p] = (ch == CW'(p)) && !sda_val;
  end

  assign irq = |(isr & ier);

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = mode_r;
      3'd1: reg_rdata = {5'd0, ack_en, 2'd0};
      3'd2: reg_rdata = {6'd0, last_ack, busy};
      3'd3: reg_rdata = {4'd0, isr};
      3'd4: reg_rdata = {4'd0, ier};
      3'd5: reg_rdata = taddr;
      3'd6: reg_rdata = sub_r;
      default: reg_rdata = data_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_r <= '0; taddr <= '0; sub_r <= '0; data_r <= '0;
      isr <= '0; ier <= '0; bitn <= '0; ack_en <= 1'b0; busy <= 1'b0;
      last_ack <= 1'b0; sbit <= 1'b1; sda_last <= 1'b1; nak_rd <= 1'b0;
      q <= '0; sh <= '1; pcnt <= '0;
    end else begin
      isr <= (isr & ~isr_clr) | isr_set;
      if (reg_we) begin
        case (reg_addr)
          3'd0: if (!busy) mode_r <= reg_wdata;
          3'd1: ack_en <= reg_wdata[2];
          3'd4: ier <= reg_wdata[3:0];
          3'd5: taddr <= reg_wdata;
          3'd6: sub_r <= reg_wdata;
          3'd7: data_r <= reg_wdata;
          default: ;
        endcase
      end
      pcnt <= (tick || st == S_IDLE || st == S_HOLD) ? '0 : pcnt + 1'b1;
      if (tick) q <= q + 2'd1;
      if (tick && q == 2'd2) sbit <= sda_in[ch];
      if (endsym) sda_last <= sda_val;
      if (endsym && bitst) begin
        sh   <= {sh[7:0], sbit};
        bitn <= bitn + 4'd1;
      end
      case (st)
        S_IDLE: if (go) begin st <= S_START; busy <= 1'b1; last_ack <= 1'b0; end
        S_START: if (endsym) begin
          st   <= S_ADDR;
          sh   <= {iscomb ? {taddr[7:1], 1'b0} : taddr, 1'b1};
          bitn <= '0;
        end
        S_RSTART: if (endsym) begin
          st   <= S_ADDR2;
          sh   <= {taddr[7:1], 1'b1, 1'b1};
          bitn <= '0;
        end
        S_ADDR, S_SUB, S_ADDR2: if (done) begin
          last_ack <= acked;
          bitn     <= '0;
          if (!acked)                     st <= S_STOP;
          else if (st == S_ADDR && !isstd) begin st <= S_SUB; sh <= {sub_r, 1'b1}; end
          else if (st == S_SUB && iscomb) st <= S_RSTART;
          else                            st <= S_HOLD;
        end
        S_WR: if (done) begin last_ack <= acked; bitn <= '0; st <= S_HOLD; end
        S_RD: if (done) begin
          data_r <= sh[7:0];
          bitn   <= '0;
          st     <= nak_rd ? S_STOP : S_HOLD;
        end
        S_HOLD: begin
          if (stop_cmd) st <= S_STOP;
          else if (rd_dir && isr_we && |reg_wdata[1:0]) begin
            st <= S_RD; sh <= {8'hFF, ~ack_en}; nak_rd <= ~ack_en;
          end else if (!rd_dir && data_we) begin
            st <= S_WR; sh <= {reg_wdata, 1'b1};
          end
        end
        S_STOP: if (endsym) begin st <= S_IDLE; busy <= 1'b0; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd0) |=> $stable(mode_r));

  a_r6_nack_autostop: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isr[0]) && !last_ack) |-> (st == S_STOP));

  a_r5_nak_read_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isr[1]) && $past(st == S_RD) && $past(nak_rd)) |-> (st == S_STOP));

  a_r11_scl_on_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(scl_rel) && $past(st != S_IDLE)) |-> $past(tick));

  a_r7_busy_ends_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st == S_STOP));
endmodule

// File: tb/i2c_sub_master_bench.sv
`timescale 1ns/1ps
module i2c_sub_master_bench;
  logic       clk = 0, rst_n = 0, we = 0;
  logic [2:0] ra = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd;
  logic       irq;
  logic [1:0] scl_pull, sda_pull, sda_in;
  int tests = 0, fails = 0, cyc = 0;

  i2c_sub_master u_i2c_sub_master (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(ra), .reg_wdata(wd),
    .reg_rdata(rd), .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in));

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  // behavioural target at 7-bit address 0x50 with an 8-byte register file
  logic       s_pull = 0, nack_wr = 0, s_rw = 0, mack = 0;
  int         sport = 0, cnt = 0, ph = 0;
  logic [7:0] mem [8];
  logic [7:0] ssh = 0, tx = 0;
  logic [2:0] ptr = 0;
  logic       pscl = 1, psda = 1, p0_touched = 0, mon_en = 0;
  wire l0 = ~(sda_pull[0] | (s_pull && sport == 0));
  wire l1 = ~(sda_pull[1] | (s_pull && sport == 1));
  assign sda_in = {l1, l0};
  wire s_scl = (sport == 1) ? ~scl_pull[1] : ~scl_pull[0];
  wire s_sda = (sport == 1) ? l1 : l0;

  always @(negedge clk) begin
    if (mon_en && (scl_pull[0] || sda_pull[0])) p0_touched = 1;
    if (pscl && s_scl && psda && !s_sda) begin cnt = 0; ph = 1; s_pull = 0; end
    else if (pscl && s_scl && !psda && s_sda) begin ph = 0; s_pull = 0; end
    else if (!pscl && s_scl) begin
      if (cnt < 8) ssh = {ssh[6:0], s_sda};
      if (cnt == 8) mack = !s_sda;
      cnt++;
    end else if (pscl && !s_scl) begin
      if (cnt == 8) begin
        case (ph)
          1: if (ssh[7:1] == 7'h50) begin s_pull = 1; s_rw = ssh[0]; ph = ssh[0] ? 4 : 2; mack = 1; end
             else ph = 0;
          2: begin ptr = ssh[2:0]; ph = 3; s_pull = 1; end
          3: if (!nack_wr) begin mem[ptr] = ssh; ptr++; s_pull = 1; end
          4: s_pull = 0;
          default: ;
        endcase
      end else if (cnt == 9) begin
        cnt = 0; s_pull = 0;
        if (ph == 4) begin
          if (mack) begin tx = mem[ptr]; ptr++; s_pull = !tx[7]; end
          else ph = 0;
        end
      end else if (ph == 4 && cnt >= 1 && cnt <= 7) s_pull = !tx[7-cnt];
    end
    pscl = s_scl; psda = s_sda;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; ra = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); ra = a; #1 v = rd;
  endtask

  task automatic wait_ev(input logic [7:0] m, input string req);
    logic [7:0] v;
    logic ok = 0;
    for (int n = 0; n < 8000 && !ok; n++) begin
      rdr(3'd3, v);
      if ((v & m) != 0) ok = 1;
    end
    if (!ok) chk({req, " event wait"}, 0, 1);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rdr(3'd2, v); chk("R1 status", v, 0);
    rdr(3'd3, v); chk("R1 events", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_pull, sda_pull}, 0);
  endtask

  task automatic t_std_write;
    logic [7:0] v;
    wr(0, 8'h00); wr(5, 8'hA0); wr(1, 8'h01);
    wait_ev(8'h01, "R2");
    rdr(3'd2, v); chk("R2 addr acked", v[1], 1);
    rdr(3'd3, v); chk("R9 start event", v[3], 1);
    wr(3, 8'h0F); wr(7, 8'h03); wait_ev(8'h02, "R2");
    rdr(3'd2, v); chk("R2 pointer acked", v[1], 1);
    wr(3, 8'h0F); wr(7, 8'hA5); wait_ev(8'h02, "R2");
    wr(3, 8'h0F); wr(1, 8'h02); wait_ev(8'h04, "R2");
    rdr(3'd2, v); chk("R2 idle after stop", v[0], 0);
    chk("R2 target byte", mem[3], 8'hA5);
    wr(3, 8'h0F);
  endtask

  task automatic t_sub_write;
    wr(0, 8'h04); wr(5, 8'hA0); wr(6, 8'h05); wr(1, 8'h01);
    wait_ev(8'h01, "R3");
    chk("R3 sub-address before addr-done", ptr, 5);
    wr(3, 8'h0F); wr(7, 8'h3C); wait_ev(8'h02, "R3");
    wr(3, 8'h0F); wr(7, 8'h7E); wait_ev(8'h02, "R3");
    wr(3, 8'h0F); wr(1, 8'h02); wait_ev(8'h04, "R3");
    chk("R3 byte 0", mem[5], 8'h3C);
    chk("R3 byte 1", mem[6], 8'h7E);
    wr(3, 8'h0F);
  endtask

  task automatic t_comb_read;
    logic [7:0] v;
    wr(0, 8'h08); wr(5, 8'hA0); wr(6, 8'h05); wr(1, 8'h05);
    wait_ev(8'h01, "R4");
    chk("R4 target saw read bit", s_rw, 1);
    rdr(3'd2, v); chk("R4 second address acked", v[1], 1);
    wr(3, 8'h0F); wait_ev(8'h02, "R4");
    rdr(3'd7, v); chk("R4 first read byte", v, 8'h3C);
    wr(1, 8'h00); wr(3, 8'h0F);
    wait_ev(8'h04, "R5");
    rdr(3'd7, v); chk("R5 last byte", v, 8'h7E);
    rdr(3'd3, v); chk("R5 data and stop events", v[2:1], 2'b11);
    rdr(3'd2, v); chk("R5 auto stop released busy", v[0], 0);
    wr(3, 8'h0F);
  endtask

  task automatic t_std_read;
    logic [7:0] v;
    wr(0, 8'h00); wr(5, 8'hA1); wr(1, 8'h01);
    wait_ev(8'h01, "R5");
    wr(3, 8'h0F); wait_ev(8'h04, "R5");
    rdr(3'd7, v); chk("R5 plain read byte", v, 8'h87);
    wr(3, 8'h0F);
  endtask

  task automatic t_addr_nack;
    logic [7:0] v;
    wr(0, 8'h00); wr(5, 8'h46); wr(1, 8'h01);
    wait_ev(8'h04, "R6");
    rdr(3'd3, v); chk("R6 addr-done and stop", v[2:0] & 3'b101, 3'b101);
    rdr(3'd2, v); chk("R6 status no ack, idle", v[1:0], 0);
  endtask

  task automatic t_isr;
    logic [7:0] v;
    wr(4, 8'h00); chk("R8 masked irq", irq, 0);
    wr(4, 8'h04); chk("R8 enabled irq", irq, 1);
    rdr(3'd3, v); chk("R8 events before clear", v, 8'h0D);
    wr(3, 8'h01); rdr(3'd3, v); chk("R8 clear one bit", v, 8'h0C);
    wr(3, 8'h00); rdr(3'd3, v); chk("R8 zero write no effect", v, 8'h0C);
    chk("R8 irq still up", irq, 1);
    wr(3, 8'h04); chk("R8 irq drops", irq, 0);
    wr(4, 8'h08); chk("R8 other mask", irq, 1);
    wr(3, 8'h0F); wr(4, 8'h00);
  endtask

  task automatic t_quick;
    logic [7:0] v;
    wr(5, 8'hA0); wr(1, 8'h01); wait_ev(8'h01, "R7");
    repeat (40) @(negedge clk);
    chk("R7 SCL held low while paused", scl_pull[0], 1);
    wr(1, 8'h02);
    rdr(3'd2, v); chk("R7 busy during stop", v[0], 1);
    wait_ev(8'h04, "R7");
    rdr(3'd2, v); chk("R7 idle, acked", v[1:0], 2'b10);
    wr(3, 8'h0F);
  endtask

  task automatic t_data_nack;
    logic [7:0] v;
    nack_wr = 1;
    wr(5, 8'hA0); wr(1, 8'h01); wait_ev(8'h01, "R13");
    wr(3, 8'h0F); wr(7, 8'h02); wait_ev(8'h02, "R13");
    wr(3, 8'h0F); wr(7, 8'h55); wait_ev(8'h02, "R13");
    rdr(3'd2, v); chk("R13 nack busy", v[1:0], 2'b01);
    repeat (100) @(negedge clk);
    chk("R13 still holding SCL", scl_pull[0], 1);
    wr(1, 8'h02); wait_ev(8'h04, "R13");
    chk("R13 target unchanged", mem[2], 8'h82);
    wr(3, 8'h0F); nack_wr = 0;
  endtask

  task automatic t_mode_busy;
    logic [7:0] v;
    wr(0, 8'h00); wr(5, 8'hA0); wr(1, 8'h01); wait_ev(8'h01, "R12");
    wr(0, 8'h55); rdr(3'd0, v); chk("R12 mode frozen", v, 8'h00);
    wr(1, 8'h02); wait_ev(8'h04, "R12"); wr(3, 8'h0F);
    wr(0, 8'h10); rdr(3'd0, v); chk("R12 mode accepted idle", v, 8'h10);
  endtask

  task automatic t_channel;
    logic [7:0] v;
    sport = 1; p0_touched = 0; mon_en = 1;
    wr(5, 8'hA0); wr(1, 8'h01); wait_ev(8'h01, "R10");
    rdr(3'd2, v); chk("R10 target on port 1 acked", v[1], 1);
    wr(1, 8'h02); wait_ev(8'h04, "R10");
    mon_en = 0;
    chk("R10 port 0 untouched", p0_touched, 0);
    wr(3, 8'h0F); sport = 0; wr(0, 8'h00);
  endtask

  task automatic t_rate(input int r);
    int t0, t1;
    wr(0, 8'(r)); wr(5, 8'hA0); wr(1, 8'h01);
    @(negedge clk); while (!scl_pull[0]) @(negedge clk);
    while (scl_pull[0]) @(negedge clk);
    t0 = cyc;
    while (!scl_pull[0]) @(negedge clk);
    while (scl_pull[0]) @(negedge clk);
    t1 = cyc;
    chk($sformatf("R11 SCL period rate %0d", r), t1 - t0, 16 << (r == 3 ? 2 : r));
    wait_ev(8'h01, "R11"); wr(1, 8'h02); wait_ev(8'h04, "R11"); wr(3, 8'h0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 8'h80 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_std_write;
    t_sub_write;
    t_comb_read;
    t_std_read;
    t_addr_nack;
    t_isr;
    t_quick;
    t_data_nack;
    t_mode_busy;
    t_channel;
    t_rate(0);
    t_rate(1);
    t_rate(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule